// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that runs memory-to-memory copies on its own. The description of each copy lives in memory as a four-word descriptor. Software writes the address of the first descriptor and rings a doorbell. It then sets the enable bit. From there the channel reads the descriptor and moves the requested number of units from source to target. If the descriptor says so, it goes on to the next descriptor in the chain. A chain ends at a descriptor whose link bit is clear. If a link offset points back to the first descriptor, the chain becomes a ring that runs until software stops it.

The channel owns a single word-wide memory port. Requests on it follow a valid/ready handshake. Once `mem_req_valid` is high, the request and all of its fields stay unchanged until a cycle in which `mem_req_ready` is also high; that cycle completes the transfer. Only one request is outstanding at a time. A read completes when the memory raises `mem_rsp_valid`, and that response channel has no back-pressure. A write is finished when it is accepted. The register side is a plain single-cycle write strobe with a read mux that has no delay.

Top module: `chain_dma_chan`

## Requirements
- R1: After a start, the channel reads the four descriptor words in this order: command, source, target, count. They are at descriptor address +0, +4, +8 and +12.
- R2: The low 24 bits of the count word give the number of units. Each unit is read from the source and then written to the target. With 4-byte units, the source and target advance by 4 after each unit.
- R3: Command bits 10:8 select the unit size, coded 0=4 B, 1=1 B, 2=2 B, 3=16 B, 4=32 B, 5=64 B, 6=128 B. For a 1- or 2-byte unit, the write carries byte enables at the target's low address bits. Its data is taken from the source word's lane.
- R4: A unit larger than a word is moved as back-to-back word beats, each a read followed by a write. A 16-byte unit is four beats at consecutive word addresses.
- R5: Command bit 23 increments the source address and command bit 22 increments the target address. When a bit is clear, that address stays the same for every beat.
- R6: When command bit 0 (link) is set, the next descriptor is fetched from the chain base plus the count word's top 8 bits times 16. An offset of 0 goes back to the first descriptor.
- R7: When a descriptor with link clear finishes, status bit 3 is set and status bit 0 (enable) is cleared. `irq` is raised only if command bit 1 was set, and it stays high until software writes the status register.
- R8: Register 1 reads the units still remaining in the current descriptor. A value written to it while the channel is idle reads back.
- R9: A source or target address that is not aligned to the unit size sets status bit 4 and stops the channel before any data request.
- R10: Unit-size code 7 sets status bit 2 (halt) and stops the channel before any data request.
- R11: Writing 0 to the status register clears every status bit. A running transfer then stops at the next unit boundary and issues no further requests.
- R12: A request stays stable while it waits for ready. Stalls on the memory port change no data and no ordering.
- R13: A transfer starts only when both a pending doorbell (register 3, bit 0) and the enable bit are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 descriptor address, 1 count, 2 status, 3 doorbell |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Completion interrupt, level |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Word-aligned byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_req_be | output | 4 | Write byte enables |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |

## Verification
The hardest state to reach is the one where software stops the channel in the middle of a chain. The abort must land inside a running ring at a known point, or between units of a long copy. For the ring, the stimulus counts fetches of the first descriptor and writes the status register while the second pass is still fetching. The only traffic allowed after that is the rest of that fetch. For the long copy, the abort lands after a few writes, and the remaining-count register must then equal the units that were never written. Random ready stalls on some runs check that back-pressure changes neither the order nor the data.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  localparam int unsigned RA_DESC  = 0;
  localparam int unsigned RA_COUNT = 1;
  localparam int unsigned RA_STAT  = 2;
  localparam int unsigned RA_BELL  = 3;

  localparam int unsigned CB_LINK = 0;
  localparam int unsigned CB_IE   = 1;
  localparam int unsigned CB_DINC = 22;
  localparam int unsigned CB_SINC = 23;

  localparam int unsigned SB_EN   = 0;
  localparam int unsigned SB_HALT = 2;
  localparam int unsigned SB_TERM = 3;
  localparam int unsigned SB_AERR = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_FWAIT, S_UNIT, S_RD, S_RWAIT, S_WR, S_END
  } eng_state_e;
endpackage

// File: rtl/cdma_size_dec.sv
module cdma_size_dec #(
  parameter int unsigned BEAT_W = 6
) (
  input  logic [2:0]        code,
  output logic              legal,
  output logic [7:0]        bytes,
  output logic [BEAT_W-1:0] beats,
  output logic [2:0]        step
);
  always_comb begin
    legal = 1'b1;
    unique case (code)
      3'd0: bytes = 8'd4;
      3'd1: bytes = 8'd1;
      3'd2: bytes = 8'd2;
      3'd3: bytes = 8'd16;
      3'd4: bytes = 8'd32;
      3'd5: bytes = 8'd64;
      3'd6: bytes = 8'd128;
      default: begin bytes = 8'd1; legal = 1'b0; end
    endcase
    if (bytes >= 8'd4) begin
      beats = BEAT_W'(bytes[7:2]);
      step  = 3'd4;
    end else begin
      beats = BEAT_W'(1);
      step  = bytes[2:0];
    end
  end
endmodule

// File: rtl/cdma_lane_mux.sv
module cdma_lane_mux (
  input  logic [31:0] rd_word,
  input  logic [1:0]  src_lo,
  input  logic [1:0]  dst_lo,
  input  logic [7:0]  bytes,
  output logic [31:0] wdata,
  output logic [3:0]  be
);
  logic [31:0] aligned;
  logic [3:0]  base_be;
  always_comb begin
    aligned = rd_word >> {src_lo, 3'b000};
    wdata   = aligned << {dst_lo, 3'b000};
    case (bytes)
      8'd1:    base_be = 4'b0001;
      8'd2:    base_be = 4'b0011;
      default: base_be = 4'b1111;
    endcase
    be = base_be << dst_lo;
  end
endmodule

// File: rtl/chain_dma_chan.sv
module chain_dma_chan #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned BEAT_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  output logic [3:0]  mem_req_be,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  import chain_dma_pkg::*;

  localparam int unsigned LINK_SH = 4;

  eng_state_e          state;
  logic [ADDR_W-1:0]   dar, base, src, dst;
  logic [31:0]         cmd, rd_hold;
  logic [CNT_W-1:0]    cnt;
  logic [OFF_W-1:0]    nxt;
  logic [1:0]          wsel;
  logic [BEAT_W-1:0]   beat;
  logic                st_en, st_halt, st_tt, st_ar, ie_flag, bell;

  logic                legal, misal;
  logic [7:0]          bytes;
  logic [BEAT_W-1:0]   beats;
  logic [2:0]          step;
  logic [31:0]         lane_wdata;
  logic [3:0]          lane_be;

  cdma_size_dec #(.BEAT_W(BEAT_W)) u_size (
    .code(cmd[10:8]), .legal(legal), .bytes(bytes), .beats(beats), .step(step)
  );

  cdma_lane_mux u_lane (
    .rd_word(rd_hold), .src_lo(src[1:0]), .dst_lo(dst[1:0]), .bytes(bytes),
    .wdata(lane_wdata), .be(lane_be)
  );

  assign misal = |((src[7:0] | dst[7:0]) & (bytes - 8'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      dar <= '0; base <= '0; src <= '0; dst <= '0;
      cmd <= '0; rd_hold <= '0; cnt <= '0; nxt <= '0;
      wsel <= '0; beat <= '0;
      st_en <= 1'b0; st_halt <= 1'b0; st_tt <= 1'b0; st_ar <= 1'b0;
      ie_flag <= 1'b0; bell <= 1'b0;
    end else begin
      if (reg_wr_en) begin
        case (reg_addr)
          2'(RA_DESC):  dar <= ADDR_W'(reg_wdata);
          2'(RA_COUNT): if (state == S_IDLE) cnt <= reg_wdata[CNT_W-1:0];
          2'(RA_STAT): begin
            st_en   <= reg_wdata[SB_EN];
            st_halt <= reg_wdata[SB_HALT];
            st_tt   <= reg_wdata[SB_TERM];
            st_ar   <= reg_wdata[SB_AERR];
          end
          default: if (reg_wdata[0]) bell <= 1'b1;
        endcase
      end
      case (state)
        S_IDLE: if (st_en && bell) begin
          bell <= 1'b0; base <= dar; wsel <= '0; ie_flag <= 1'b0;
          state <= S_FETCH;
        end
        S_FETCH: if (mem_req_ready) state <= S_FWAIT;
        S_FWAIT: if (mem_rsp_valid) begin
          case (wsel)
            2'd0: cmd <= mem_rsp_data;
            2'd1: src <= ADDR_W'(mem_rsp_data);
            2'd2: dst <= ADDR_W'(mem_rsp_data);
            default: begin
              cnt <= mem_rsp_data[CNT_W-1:0];
              nxt <= mem_rsp_data[31 -: OFF_W];
            end
          endcase
          if (wsel == 2'd3) state <= S_UNIT;
          else begin wsel <= wsel + 2'd1; state <= S_FETCH; end
        end
        S_UNIT: begin
          if (!st_en) state <= S_IDLE;
          else if (cnt == '0) state <= S_END;
          else if (!legal) begin st_halt <= 1'b1; st_en <= 1'b0; state <= S_IDLE; end
          else if (misal) begin st_ar <= 1'b1; st_en <= 1'b0; state <= S_IDLE; end
          else begin beat <= '0; state <= S_RD; end
        end
        S_RD: if (mem_req_ready) state <= S_RWAIT;
        S_RWAIT: if (mem_rsp_valid) begin rd_hold <= mem_rsp_data; state <= S_WR; end
        S_WR: if (mem_req_ready) begin
          if (cmd[CB_SINC]) src <= src + ADDR_W'(step);
          if (cmd[CB_DINC]) dst <= dst + ADDR_W'(step);
          if (beat == beats - BEAT_W'(1)) begin
            cnt <= cnt - CNT_W'(1); state <= S_UNIT;
          end else begin
            beat <= beat + BEAT_W'(1); state <= S_RD;
          end
        end
        default: begin
          if (cmd[CB_LINK]) begin
            dar <= base + ADDR_W'({nxt, LINK_SH'(0)});
            wsel <= '0; state <= S_FETCH;
          end else begin
            st_tt <= 1'b1; st_en <= 1'b0; ie_flag <= cmd[CB_IE]; state <= S_IDLE;
          end
        end
      endcase
    end
  end

  always_comb begin
    mem_req_valid = (state == S_FETCH) || (state == S_RD) || (state == S_WR);
    mem_req_write = (state == S_WR);
    mem_req_wdata = lane_wdata;
    mem_req_be    = (state == S_WR) ? lane_be : 4'b0000;
    case (state)
      S_RD:    mem_req_addr = 32'({src[ADDR_W-1:2], 2'b00});
      S_WR:    mem_req_addr = 32'({dst[ADDR_W-1:2], 2'b00});
      default: mem_req_addr = 32'(dar + ADDR_W'({wsel, 2'b00}));
    endcase
    case (reg_addr)
      2'(RA_DESC):  reg_rdata = 32'(dar);
      2'(RA_COUNT): reg_rdata = 32'(cnt);
      2'(RA_STAT):  reg_rdata = {27'd0, st_ar, st_tt, st_halt, 1'b0, st_en};
      default:      reg_rdata = {31'd0, bell};
    endcase
  end

  assign irq = st_tt & ie_flag;

  logic unused_bits;
  assign unused_bits = ^{cmd[31:24], cmd[21:11], cmd[7:2]};
endmodule

// File: rtl/chain_dma_chan_chk.sv
module chain_dma_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        irq,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [31:0] mem_req_addr,
  input logic [31:0] mem_req_wdata,
  input logic [3:0]  mem_req_be,
  input logic        st_en,
  input logic        st_tt,
  input logic        st_halt,
  input logic        st_ar
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata) && $stable(mem_req_be));

  assert_irq_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> st_tt && !st_en);

  assert_fault_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ar) |-> !st_en);

  assert_halt_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_halt) |-> !st_en);

  assert_abort_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && reg_addr == 2'd2 && reg_wdata == 32'd0 |=> !st_en && !st_ar && !st_halt);

  assert_write_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_be != 4'b0000);
endmodule

bind chain_dma_chan chain_dma_chan_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .mem_req_be(mem_req_be), .st_en(st_en), .st_tt(st_tt),
  .st_halt(st_halt), .st_ar(st_ar)
);

// File: tb/chain_dma_chan_tb_top.sv
`timescale 1ns/1ps
module chain_dma_chan_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [3:0]  mem_req_be;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = 32'd0;

  chain_dma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  typedef struct {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    string       tag;
  } item_t;

  item_t q[$];
  logic [31:0] mem [0:1023];
  int checks = 0, fails = 0, reqs = 0, wcount = 0, ring_hits = 0, cyc = 0;
  logic [31:0] ring_base = 32'hFFFF_FFFF;
  logic stall = 1'b0;
  logic [7:0] lfsr = 8'h5A;

  // memory model
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready <= !stall || lfsr[0];
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        for (int b = 0; b < 4; b++)
          if (mem_req_be[b]) mem[mem_req_addr[11:2]][8*b +: 8] <= mem_req_wdata[8*b +: 8];
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[11:2]];
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      item_t e;
      reqs++;
      if (mem_req_write) wcount++;
      if (!mem_req_write && mem_req_addr == ring_base) ring_hits++;
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R12 unexpected request act=%h wr=%0d exp=none", mem_req_addr, mem_req_write);
      end else begin
        e = q.pop_front();
        if (e.wr !== mem_req_write || e.addr !== mem_req_addr ||
            (e.wr && (e.be !== mem_req_be ||
             ((mem_req_wdata ^ e.data) & {{8{e.be[3]}},{8{e.be[2]}},{8{e.be[1]}},{8{e.be[0]}}}) != 0))) begin
          fails++;
          $display("FAIL %s act=wr%0d %h %h be%h exp=wr%0d %h %h be%h", e.tag,
                   mem_req_write, mem_req_addr, mem_req_wdata, mem_req_be,
                   e.wr, e.addr, e.data, e.be);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    s = 32'd1;
    while (s[0]) reg_read(2'd2, s);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] mk_cmd(bit link, bit ie, int code, bit sinc, bit dinc);
    return (32'(sinc) << 23) | (32'(dinc) << 22) | (32'(code) << 8) | (32'(ie) << 1) | 32'(link);
  endfunction

  task automatic put_desc(logic [31:0] a, logic [31:0] c, logic [31:0] s, logic [31:0] d,
                          int n, int off);
    mem[a[11:2]]     = c;
    mem[a[11:2] + 1] = s;
    mem[a[11:2] + 2] = d;
    mem[a[11:2] + 3] = {8'(off), 24'(n)};
  endtask

  task automatic push(bit wr, logic [31:0] a, logic [31:0] d, logic [3:0] be, string tag);
    item_t e;
    e.wr = wr; e.addr = a; e.data = d; e.be = be; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic expect_fetch(logic [31:0] a, string tag);
    for (int k = 0; k < 4; k++) push(1'b0, a + 32'(4*k), 32'd0, 4'd0, tag);
  endtask

  task automatic expect_data(logic [31:0] a, string tag);
    logic [31:0] c, s, d, w;
    int n, sz, bb;
    c = mem[a[11:2]]; s = mem[a[11:2] + 1]; d = mem[a[11:2] + 2];
    n = int'(mem[a[11:2] + 3][23:0]);
    case (c[10:8])
      3'd0: sz = 4;  3'd1: sz = 1;  3'd2: sz = 2;  3'd3: sz = 16;
      3'd4: sz = 32; 3'd5: sz = 64; 3'd6: sz = 128; default: sz = 0;
    endcase
    if (sz == 0) return;
    if (((s | d) & 32'(sz - 1)) != 0) return;
    bb = (sz < 4) ? sz : 4;
    for (int u = 0; u < n; u++)
      for (int b = 0; b < sz / bb; b++) begin
        push(1'b0, {s[31:2], 2'b00}, 32'd0, 4'd0, tag);
        w = (mem[s[11:2]] >> (8 * s[1:0])) << (8 * d[1:0]);
        push(1'b1, {d[31:2], 2'b00}, w,
             4'((sz == 1 ? 1 : sz == 2 ? 3 : 15) << d[1:0]), tag);
        if (c[23]) s = s + 32'(bb);
        if (c[22]) d = d + 32'(bb);
      end
  endtask

  task automatic start(logic [31:0] a);
    reg_write(2'd0, a);
    reg_write(2'd3, 32'd1);
    reg_write(2'd2, 32'd1);
  endtask

  initial begin
    logic [31:0] v;
    int r0, w0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'(i) * 32'h9E37_79B1 + 32'h1357;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    reg_read(2'd2, v); check("R7 reset status", v, 32'd0);
    reg_read(2'd1, v); check("R8 reset count", v, 32'd0);
    check("R7 reset irq", 32'(irq), 32'd0);
    check("R12 reset valid", 32'(mem_req_valid), 32'd0);

    // R8: count write while idle
    reg_write(2'd1, 32'd7);
    reg_read(2'd1, v); check("R8 idle count write", v, 32'd7);

    // R13 doorbell without enable, then plain 4B copy with interrupt (R1, R2, R7)
    put_desc(32'h000, mk_cmd(0, 1, 0, 1, 1), 32'h200, 32'h300, 3, 0);
    reg_write(2'd0, 32'h000);
    reg_write(2'd3, 32'd1);
    repeat (20) @(negedge clk);
    check("R13 no request without enable", 32'(reqs), 32'd0);
    expect_fetch(32'h000, "R1 fetch");
    expect_data(32'h000, "R2 copy");
    reg_write(2'd2, 32'd1);
    wait_idle();
    check("R2 queue drained", 32'(q.size()), 32'd0);
    reg_read(2'd2, v); check("R7 terminated status", v, 32'h8);
    check("R7 irq raised", 32'(irq), 32'd1);
    reg_read(2'd1, v); check("R8 count after finish", v, 32'd0);
    reg_write(2'd2, 32'd0);
    check("R7 irq cleared", 32'(irq), 32'd0);

    // R3: 1-byte units at odd lanes, no interrupt
    put_desc(32'h010, mk_cmd(0, 0, 1, 1, 1), 32'h241, 32'h342, 3, 0);
    expect_fetch(32'h010, "R1 fetch");
    expect_data(32'h010, "R3 byte lanes");
    start(32'h010);
    wait_idle();
    check("R3 queue drained", 32'(q.size()), 32'd0);
    check("R7 no irq without enable bit", 32'(irq), 32'd0);
    reg_read(2'd2, v); check("R7 status no irq", v, 32'h8);

    // R4: 16-byte units, stalls on (R12)
    stall = 1'b1;
    put_desc(32'h020, mk_cmd(0, 0, 3, 1, 1), 32'h400, 32'h500, 2, 0);
    expect_fetch(32'h020, "R1 fetch");
    expect_data(32'h020, "R4 wide beats");
    start(32'h020);
    wait_idle();
    check("R4 queue drained", 32'(q.size()), 32'd0);

    // R5: fixed source
    put_desc(32'h030, mk_cmd(0, 0, 0, 0, 1), 32'h480, 32'h580, 3, 0);
    expect_fetch(32'h030, "R1 fetch");
    expect_data(32'h030, "R5 fixed source");
    start(32'h030);
    wait_idle();
    check("R5 queue drained", 32'(q.size()), 32'd0);

    // R6: linked chain 0x040 -> 0x060, 2-byte units in second
    put_desc(32'h040, mk_cmd(1, 0, 0, 1, 1), 32'h620, 32'h720, 2, 2);
    put_desc(32'h060, mk_cmd(0, 1, 2, 1, 1), 32'h632, 32'h736, 2, 0);
    expect_fetch(32'h040, "R1 fetch");
    expect_data(32'h040, "R6 first link");
    expect_fetch(32'h060, "R6 linked fetch");
    expect_data(32'h060, "R3 halfword lanes");
    reg_write(2'd2, 32'd0);
    start(32'h040);
    wait_idle();
    stall = 1'b0;
    check("R6 queue drained", 32'(q.size()), 32'd0);
    check("R7 irq chain end", 32'(irq), 32'd1);
    reg_write(2'd2, 32'd0);

    // R6 ring + R11 abort during second pass fetch
    put_desc(32'h080, mk_cmd(1, 0, 0, 1, 1), 32'h600, 32'h7A0, 2, 1);
    put_desc(32'h090, mk_cmd(1, 0, 0, 1, 1), 32'h610, 32'h7C0, 1, 0);
    expect_fetch(32'h080, "R1 fetch");
    expect_data(32'h080, "R6 ring first");
    expect_fetch(32'h090, "R6 ring second");
    expect_data(32'h090, "R6 ring second");
    expect_fetch(32'h080, "R6 ring wrap");
    ring_hits = 0;
    ring_base = 32'h080;
    start(32'h080);
    wait (ring_hits == 2);
    reg_write(2'd2, 32'd0);
    repeat (30) @(negedge clk);
    ring_base = 32'hFFFF_FFFF;
    check("R11 ring abort queue", 32'(q.size()), 32'd0);
    reg_read(2'd2, v); check("R11 status cleared", v, 32'd0);

    // R11/R8: abort during long copy, count reflects remaining units
    put_desc(32'h0A0, mk_cmd(0, 1, 0, 1, 1), 32'h800, 32'h900, 50, 0);
    expect_fetch(32'h0A0, "R1 fetch");
    expect_data(32'h0A0, "R11 partial copy");
    w0 = wcount;
    start(32'h0A0);
    wait (wcount >= w0 + 5);
    reg_write(2'd2, 32'd0);
    repeat (30) @(negedge clk);
    r0 = reqs;
    repeat (30) @(negedge clk);
    check("R11 no requests after abort", 32'(reqs), 32'(r0));
    reg_read(2'd1, v); check("R8 remaining after abort", v, 32'(50 - (wcount - w0)));
    check("R11 no irq after abort", 32'(irq), 32'd0);
    q.delete();

    // R9: misaligned source
    put_desc(32'h0C0, mk_cmd(0, 1, 0, 1, 1), 32'h202, 32'h300, 2, 0);
    expect_fetch(32'h0C0, "R1 fetch");
    w0 = wcount;
    start(32'h0C0);
    wait_idle();
    reg_read(2'd2, v); check("R9 address fault status", v, 32'h10);
    check("R9 no data moved", 32'(wcount - w0), 32'd0);
    check("R9 queue drained", 32'(q.size()), 32'd0);
    reg_write(2'd2, 32'd0);

    // R10: illegal size code
    put_desc(32'h0D0, mk_cmd(0, 1, 7, 1, 1), 32'h200, 32'h300, 2, 0);
    expect_fetch(32'h0D0, "R1 fetch");
    start(32'h0D0);
    wait_idle();
    reg_read(2'd2, v); check("R10 halt status", v, 32'h4);
    check("R10 queue drained", 32'(q.size()), 32'd0);
    check("R10 no irq", 32'(irq), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule